// File: doc/BRIEF.md
# Prioritized Nested Event Controller

This block sits next to an instruction sequencer and decides when a pending event is taken. Each of its `NLEV` priority levels has a request line. Level 0 is the highest priority and is used for emulation. Level 1 is the non-maskable interrupt and level 2 is the exception level. Level 4 is reserved as a global interrupt-disable flag. Every other level is an ordinary interrupt.

A rising edge on a request line sets that level's latched bit. A latched event is taken when three things hold: its latched bit is set, its mask bit is set (emulation and non-maskable events skip this test), and its level is strictly higher in priority than the current level. The current level is the index of the lowest set pending bit.

When an event is taken, the block produces a one-cycle pulse carrying the following:
- the vector-table entry of that level as the redirect fetch address;
- a flush code whose extent depends on the event class;
- a write strobe for the return register that belongs to that class;
- the return address captured from the sequencer.

Handlers may nest. A return strobe retires the highest-priority handler. Taking any interrupt also raises the global-disable pending bit. That bit stays set until software reports that it has saved the interrupt return address.

Top module: `nested_evt_ctl`

## Requirements
- R1: A rising edge on `req_i[k]` sets `ilat_o[k]` at that clock edge. A request held high does not set the bit again after it has been taken. `req_i[4]` never sets any bit.
- R2: A one in `lat_clr_i[k]` clears `ilat_o[k]` at the next edge. If a new rising edge on `req_i[k]` arrives in the same cycle, the set wins.
- R3: Latched level k is taken only when all three conditions hold:
  - `imask_i[k]` is 1, or k is 0 or 1;
  - k is less than `cur_lvl_o`;
  - `rti_i` is low.
  
  Among the eligible levels, the lowest index wins.
- R4: One clock edge after an event at level k is taken, `fetch_vld_o` is high for one cycle. At the same time `fetch_addr_o` equals `vec_tbl_i[k*AW +: AW]`.
- R5: The flush code is encoded as follows:
  - `flush_o` = 1 (whole pipeline) for levels 0, 1 and all interrupt levels;
  - `flush_o` = 2 (younger than the excepting instruction) for level 2 when `exc_err_i` was 0 at the edge that latched it;
  - `flush_o` = 3 (excepting instruction and younger) for level 2 when `exc_err_i` was 1 at that edge;
  - `flush_o` = 0 when no event is taken.
- R6: `ret_we_o` is one-hot together with `fetch_vld_o`:
  - bit 0 for interrupts;
  - bit 1 for exceptions;
  - bit 2 for the non-maskable interrupt;
  - bit 3 for emulation.
  
  `ret_addr_o` holds `retaddr_i` as sampled at the edge where the event was taken.
- R7: `mode_o` is 2 (emulation) while `ipend_o[0]` is set. Otherwise it is 1 (supervisor) while any pending bit is set, and 0 (user) when no pending bit is set.
- R8: Taking level k clears `ilat_o[k]` and sets `ipend_o[k]` at the same edge. Taking an interrupt-class level also sets `ipend_o[4]`. Levels 0 to 2 do not set `ipend_o[4]`.
- R9: `ipend_o[4]` clears at the edge after a cycle with `gdis_clr_i` high. While it is set, no level above 4 is taken; such an event stays latched until the bit clears.
- R10: `rti_i` clears the lowest-index set pending bit other than bit 4. This lowers the current level, so lower-priority events can then be taken.
- R11: `cur_lvl_o` is the index of the lowest set bit of `ipend_o`, or `NLEV` when `ipend_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NLEV | Per-level event request lines, latched on rising edge |
| imask_i | input | NLEV | Software mask, 1 enables a level |
| vec_tbl_i | input | NLEV*AW | Handler address per level, level k at bits k*AW |
| exc_err_i | input | 1 | Exception class with level-2 request: 1 error, 0 service |
| lat_clr_i | input | NLEV | Write-one-to-clear of latched bits |
| rti_i | input | 1 | Return from the current handler |
| gdis_clr_i | input | 1 | Software has saved the interrupt return address |
| retaddr_i | input | AW | Address after the last completed instruction |
| fetch_vld_o | output | 1 | One-cycle redirect strobe |
| fetch_addr_o | output | AW | Redirect fetch address |
| flush_o | output | 2 | Flush extent code |
| ret_we_o | output | 4 | Return-register write strobes by class |
| ret_addr_o | output | AW | Return address to write |
| mode_o | output | 2 | Processor mode |
| ilat_o | output | NLEV | Latched event bits |
| ipend_o | output | NLEV | Pending (in-service) bits |
| cur_lvl_o | output | $clog2(NLEV+1) | Current priority level, NLEV when idle |

## Verification
The hardest case to reach is a higher-priority interrupt that has been latched but is held off only by the global-disable bit. This happens after an interrupt has been taken and before software reports that the return address is saved. The stimulus takes level 9 and then raises level 6. It checks that level 6 stays latched with no redirect, and then pulses the save strobe to release it, which nests a second handler. Emulation nested over the non-maskable interrupt, simultaneous requests, and a request held high across its own service are also driven. The scoreboard expects exactly one redirect per taken event.

// File: rtl/nested_evt_pkg.sv
package nested_evt_pkg;
   localparam int LV_EMU  = 0;
   localparam int LV_NMI  = 1;
   localparam int LV_EXC  = 2;
   localparam int LV_GDIS = 4;

   typedef enum logic [1:0] {
      FL_NONE     = 2'd0,
      FL_ALL      = 2'd1,
      FL_YOUNGER  = 2'd2,
      FL_FROM_EXC = 2'd3
   } flush_e;

   typedef enum logic [1:0] {
      MD_USER = 2'd0,
      MD_SUPV = 2'd1,
      MD_EMU  = 2'd2
   } mode_e;

   localparam logic [3:0] RW_INT = 4'b0001;
   localparam logic [3:0] RW_EXC = 4'b0010;
   localparam logic [3:0] RW_NMI = 4'b0100;
   localparam logic [3:0] RW_EMU = 4'b1000;
endpackage

// File: rtl/evc_first_set.sv
module evc_first_set #(
   parameter int W  = 16,
   parameter int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec_i,
   output logic          found_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      found_o = |vec_i;
      idx_o   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IW'(i);
      end
   end
endmodule

// File: rtl/evc_latch.sv
module evc_latch
   import nested_evt_pkg::*;
#(
   parameter int NLEV = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NLEV-1:0] req_i,
   input  logic [NLEV-1:0] clr_i,
   input  logic [NLEV-1:0] take_i,
   input  logic            exc_err_i,
   output logic [NLEV-1:0] ilat_o,
   output logic            exc_err_o
);
   localparam logic [NLEV-1:0] NO_LATCH = NLEV'(1) << LV_GDIS;

   logic [NLEV-1:0] req_q, ilat_q, rise;

   assign rise = req_i & ~req_q & ~NO_LATCH;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q     <= '0;
         ilat_q    <= '0;
         exc_err_o <= 1'b0;
      end else begin
         req_q  <= req_i;
         ilat_q <= (ilat_q & ~clr_i & ~take_i) | rise;
         if (rise[LV_EXC]) exc_err_o <= exc_err_i;
      end
   end

   assign ilat_o = ilat_q;

   // R1: a latched bit only appears after a rising request edge
   assert_set_by_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ((ilat_q & ~$past(ilat_q)) & ~$past(req_i & ~req_q & ~NO_LATCH)) == '0);
endmodule

// File: rtl/evc_pend.sv
module evc_pend
   import nested_evt_pkg::*;
#(
   parameter int NLEV = 16,
   parameter int IW   = $clog2(NLEV)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            acc_i,
   input  logic [IW-1:0]   acc_lvl_i,
   input  logic            acc_int_i,
   input  logic            rti_i,
   input  logic            gdis_clr_i,
   output logic [NLEV-1:0] ipend_o
);
   localparam logic [NLEV-1:0] GDIS_BIT = NLEV'(1) << LV_GDIS;

   logic [NLEV-1:0] ipend_q, ipend_n;
   logic            ret_found;
   logic [IW-1:0]   ret_idx;

   evc_first_set #(.W(NLEV), .IW(IW)) u_ret_sel (
      .vec_i   (ipend_q & ~GDIS_BIT),
      .found_o (ret_found),
      .idx_o   (ret_idx)
   );

   always_comb begin
      ipend_n = ipend_q;
      if (rti_i && ret_found) ipend_n = ipend_n & ~(NLEV'(1) << ret_idx);
      if (gdis_clr_i)         ipend_n = ipend_n & ~GDIS_BIT;
      if (acc_i) begin
         ipend_n = ipend_n | (NLEV'(1) << acc_lvl_i);
         if (acc_int_i) ipend_n = ipend_n | GDIS_BIT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ipend_q <= '0;
      else        ipend_q <= ipend_n;
   end

   assign ipend_o = ipend_q;

   // R10: a return retires exactly one handler
   assert_rti_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rti_i && !acc_i && !gdis_clr_i && ((ipend_q & ~GDIS_BIT) != '0))
      |=> ($countones(ipend_q) == $countones($past(ipend_q)) - 1));
endmodule

// File: rtl/nested_evt_ctl.sv
module nested_evt_ctl
   import nested_evt_pkg::*;
#(
   parameter int NLEV = 16,
   parameter int AW   = 32,
   localparam int IW  = $clog2(NLEV),
   localparam int LW  = $clog2(NLEV + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NLEV-1:0]    req_i,
   input  logic [NLEV-1:0]    imask_i,
   input  logic [NLEV*AW-1:0] vec_tbl_i,
   input  logic               exc_err_i,
   input  logic [NLEV-1:0]    lat_clr_i,
   input  logic               rti_i,
   input  logic               gdis_clr_i,
   input  logic [AW-1:0]      retaddr_i,
   output logic               fetch_vld_o,
   output logic [AW-1:0]      fetch_addr_o,
   output logic [1:0]         flush_o,
   output logic [3:0]         ret_we_o,
   output logic [AW-1:0]      ret_addr_o,
   output logic [1:0]         mode_o,
   output logic [NLEV-1:0]    ilat_o,
   output logic [NLEV-1:0]    ipend_o,
   output logic [LW-1:0]      cur_lvl_o
);
   if (NLEV < 6 || NLEV > 32) begin : g_bad_nlev
      $error("nested_evt_ctl: NLEV must lie in 6..32");
   end
   if (AW < 2) begin : g_bad_aw
      $error("nested_evt_ctl: AW must be at least 2");
   end

   logic [NLEV-1:0] ilat, ipend, elig, take;
   logic            exc_err_q, pend_found, win_found, acc, acc_int;
   logic [IW-1:0]   pend_idx, win;
   logic [LW-1:0]   cur_lvl;
   flush_e          flush_n;
   logic [3:0]      we_n;

   logic            fetch_vld_q;
   logic [AW-1:0]   fetch_addr_q, ret_addr_q;
   flush_e          flush_q;
   logic [3:0]      we_q;
   logic [IW-1:0]   acc_lvl_q;

   evc_latch #(.NLEV(NLEV)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req_i),
      .clr_i     (lat_clr_i),
      .take_i    (take),
      .exc_err_i (exc_err_i),
      .ilat_o    (ilat),
      .exc_err_o (exc_err_q)
   );

   evc_first_set #(.W(NLEV), .IW(IW)) u_cur_sel (
      .vec_i   (ipend),
      .found_o (pend_found),
      .idx_o   (pend_idx)
   );

   assign cur_lvl = pend_found ? LW'(pend_idx) : LW'(NLEV);

   for (genvar k = 0; k < NLEV; k++) begin : g_elig
      if (k == LV_EMU || k == LV_NMI) begin : g_unmaskable
         assign elig[k] = ilat[k] & (cur_lvl > LW'(k));
      end else begin : g_maskable
         assign elig[k] = ilat[k] & imask_i[k] & (cur_lvl > LW'(k));
      end
   end

   evc_first_set #(.W(NLEV), .IW(IW)) u_win_sel (
      .vec_i   (elig),
      .found_o (win_found),
      .idx_o   (win)
   );

   assign acc     = win_found & ~rti_i;
   assign take    = acc ? (NLEV'(1) << win) : '0;
   assign acc_int = (win != IW'(LV_EMU)) && (win != IW'(LV_NMI)) && (win != IW'(LV_EXC));

   always_comb begin
      flush_n = FL_ALL;
      we_n    = RW_INT;
      if (win == IW'(LV_EMU)) begin
         we_n = RW_EMU;
      end else if (win == IW'(LV_NMI)) begin
         we_n = RW_NMI;
      end else if (win == IW'(LV_EXC)) begin
         we_n    = RW_EXC;
         flush_n = exc_err_q ? FL_FROM_EXC : FL_YOUNGER;
      end
   end

   evc_pend #(.NLEV(NLEV), .IW(IW)) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_i      (acc),
      .acc_lvl_i  (win),
      .acc_int_i  (acc_int),
      .rti_i      (rti_i),
      .gdis_clr_i (gdis_clr_i),
      .ipend_o    (ipend)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetch_vld_q  <= 1'b0;
         fetch_addr_q <= '0;
         flush_q      <= FL_NONE;
         we_q         <= '0;
         ret_addr_q   <= '0;
         acc_lvl_q    <= '0;
      end else begin
         fetch_vld_q <= acc;
         flush_q     <= acc ? flush_n : FL_NONE;
         we_q        <= acc ? we_n : 4'b0000;
         if (acc) begin
            fetch_addr_q <= vec_tbl_i[win*AW +: AW];
            ret_addr_q   <= retaddr_i;
            acc_lvl_q    <= win;
         end
      end
   end

   assign fetch_vld_o  = fetch_vld_q;
   assign fetch_addr_o = fetch_addr_q;
   assign flush_o      = flush_q;
   assign ret_we_o     = we_q;
   assign ret_addr_o   = ret_addr_q;
   assign ilat_o       = ilat;
   assign ipend_o      = ipend;
   assign cur_lvl_o    = cur_lvl;
   assign mode_o       = ipend[LV_EMU] ? MD_EMU : (pend_found ? MD_SUPV : MD_USER);

   // R6: at most one return register written
   assert_one_ret_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ret_we_o));
   // R8: the level just taken is in service
   assert_taken_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_vld_o |-> ipend[acc_lvl_q]);
   // R8: an interrupt raises the global-disable bit
   assert_int_sets_gdis_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_vld_o && acc_lvl_q > IW'(LV_EXC)) |-> ipend[LV_GDIS]);
   // R9: nothing below the disable level is taken while it is set
   assert_gdis_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_vld_o && $past(ipend[LV_GDIS])) |-> (acc_lvl_q < IW'(LV_GDIS)));
   // R3: a taken level outranked the level current at that time
   assert_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_vld_o |-> ($past(cur_lvl) > LW'(acc_lvl_q)));
endmodule

// File: tb/test_nested_evt_ctl.sv
`timescale 1ns/1ps
module test_nested_evt_ctl;
   localparam int NLEV = 16;
   localparam int AW   = 32;

   typedef struct packed {
      logic [AW-1:0] addr;
      logic [1:0]    fl;
      logic [3:0]    we;
      logic [AW-1:0] ra;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NLEV-1:0] req_i = '0, imask_i = '1, lat_clr_i = '0;
   logic [NLEV*AW-1:0] vec_tbl_i;
   logic exc_err_i = 1'b0, rti_i = 1'b0, gdis_clr_i = 1'b0;
   logic [AW-1:0] retaddr_i = '0;
   logic fetch_vld_o;
   logic [AW-1:0] fetch_addr_o, ret_addr_o;
   logic [1:0] flush_o, mode_o;
   logic [3:0] ret_we_o;
   logic [NLEV-1:0] ilat_o, ipend_o;
   logic [4:0] cur_lvl_o;

   int nvec = 0, nerr = 0;
   bit done = 1'b0;
   exp_t expq[$];

   always #2 clk = ~clk;

   for (genvar k = 0; k < NLEV; k++) begin : g_vec
      assign vec_tbl_i[k*AW +: AW] = 32'h0000_1000 + 32'(k) * 32'h40;
   end

   nested_evt_ctl #(.NLEV(NLEV), .AW(AW)) i_nested_evt_ctl (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .imask_i(imask_i),
      .vec_tbl_i(vec_tbl_i), .exc_err_i(exc_err_i), .lat_clr_i(lat_clr_i),
      .rti_i(rti_i), .gdis_clr_i(gdis_clr_i), .retaddr_i(retaddr_i),
      .fetch_vld_o(fetch_vld_o), .fetch_addr_o(fetch_addr_o), .flush_o(flush_o),
      .ret_we_o(ret_we_o), .ret_addr_o(ret_addr_o), .mode_o(mode_o),
      .ilat_o(ilat_o), .ipend_o(ipend_o), .cur_lvl_o(cur_lvl_o)
   );

   task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_evt(int lvl, logic [1:0] fl, logic [3:0] we, logic [AW-1:0] ra);
      exp_t e;
      e.addr = 32'h0000_1000 + 32'(lvl) * 32'h40;
      e.fl = fl; e.we = we; e.ra = ra;
      retaddr_i = ra;
      expq.push_back(e);
   endtask

   task automatic pulse_req(int lvl);
      req_i[lvl] = 1'b1; idle(1); req_i[lvl] = 1'b0;
   endtask
   task automatic pulse_rti();
      rti_i = 1'b1; idle(1); rti_i = 1'b0;
   endtask
   task automatic pulse_gdis();
      gdis_clr_i = 1'b1; idle(1); gdis_clr_i = 1'b0;
   endtask

   // monitor: pops one expected redirect per observed fetch strobe (R4 R5 R6)
   always @(negedge clk) begin
      if (rst_n && fetch_vld_o) begin
         if (expq.size() == 0) begin
            chk("R4 unexpected redirect", fetch_addr_o, 32'hFFFF_FFFF);
         end else begin
            exp_t e;
            e = expq.pop_front();
            chk("R4 fetch address", fetch_addr_o, e.addr);
            chk("R5 flush code", 32'(flush_o), 32'(e.fl));
            chk("R6 return strobe", 32'(ret_we_o), 32'(e.we));
            chk("R6 return address", ret_addr_o, e.ra);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nvec++; nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // reset state (R11 R7)
      chk("R11 idle level", 32'(cur_lvl_o), 32'd16);
      chk("R8 pending after reset", 32'(ipend_o), 32'h0);
      chk("R1 latched after reset", 32'(ilat_o), 32'h0);
      chk("R7 user mode", 32'(mode_o), 32'd0);
      chk("R4 no strobe", 32'(fetch_vld_o), 32'd0);

      // interrupt at level 9
      expect_evt(9, 2'd1, 4'b0001, 32'hC000_0009);
      pulse_req(9); idle(3);
      chk("R8 pending int plus disable", 32'(ipend_o), 32'h0210);
      chk("R8 latched cleared", 32'(ilat_o), 32'h0);
      chk("R11 level is disable bit", 32'(cur_lvl_o), 32'd4);
      chk("R7 supervisor", 32'(mode_o), 32'd1);

      // level 6 held off by global disable
      pulse_req(6); idle(3);
      chk("R9 level 6 waits latched", 32'(ilat_o), 32'h0040);
      chk("R9 pending unchanged", 32'(ipend_o), 32'h0210);
      expect_evt(6, 2'd1, 4'b0001, 32'hC000_0006);
      pulse_gdis(); idle(3);
      chk("R9 nested after release", 32'(ipend_o), 32'h0250);
      pulse_gdis(); idle(2);
      chk("R9 disable cleared", 32'(ipend_o), 32'h0240);
      chk("R11 level 6", 32'(cur_lvl_o), 32'd6);
      pulse_rti(); idle(2);
      chk("R10 return to level 9", 32'(ipend_o), 32'h0200);
      chk("R11 level 9", 32'(cur_lvl_o), 32'd9);
      pulse_rti(); idle(2);
      chk("R10 all retired", 32'(ipend_o), 32'h0);
      chk("R7 back to user", 32'(mode_o), 32'd0);

      // masked level 11, clearing by software
      imask_i = ~16'h0800;
      pulse_req(11); idle(3);
      chk("R3 masked stays latched", 32'(ilat_o), 32'h0800);
      lat_clr_i = 16'h0800; idle(1); lat_clr_i = '0; idle(1);
      chk("R2 cleared by software", 32'(ilat_o), 32'h0);
      req_i[11] = 1'b1; lat_clr_i = 16'h0800; idle(1);
      req_i[11] = 1'b0; lat_clr_i = '0; idle(1);
      chk("R2 set wins over clear", 32'(ilat_o), 32'h0800);
      lat_clr_i = 16'h0800; idle(1); lat_clr_i = '0; idle(1);

      // non-maskable then emulation nested on top, all masked
      imask_i = '0;
      expect_evt(1, 2'd1, 4'b0100, 32'hC000_0001);
      pulse_req(1); idle(3);
      chk("R8 nmi sets no disable bit", 32'(ipend_o), 32'h0002);
      chk("R7 supervisor for nmi", 32'(mode_o), 32'd1);
      expect_evt(0, 2'd1, 4'b1000, 32'hC000_0000);
      pulse_req(0); idle(3);
      chk("R8 emulation nested", 32'(ipend_o), 32'h0003);
      chk("R7 emulation mode", 32'(mode_o), 32'd2);
      pulse_rti(); idle(2);
      chk("R10 emulation retired", 32'(ipend_o), 32'h0002);
      chk("R7 supervisor again", 32'(mode_o), 32'd1);
      pulse_rti(); idle(2);

      // exceptions of both classes
      imask_i = '1;
      exc_err_i = 1'b0;
      expect_evt(2, 2'd2, 4'b0010, 32'hC000_0002);
      pulse_req(2); idle(3);
      chk("R8 exception pending only", 32'(ipend_o), 32'h0004);
      pulse_rti(); idle(2);
      exc_err_i = 1'b1;
      expect_evt(2, 2'd3, 4'b0010, 32'hC000_0012);
      pulse_req(2); exc_err_i = 1'b0; idle(3);
      pulse_rti(); idle(2);

      // simultaneous levels 7 and 12
      expect_evt(7, 2'd1, 4'b0001, 32'hC000_0007);
      req_i[7] = 1'b1; req_i[12] = 1'b1; idle(1);
      req_i[7] = 1'b0; req_i[12] = 1'b0; idle(3);
      chk("R3 lower index first", 32'(ipend_o), 32'h0090);
      chk("R3 other waits", 32'(ilat_o), 32'h1000);
      pulse_gdis(); idle(3);
      chk("R3 lower priority still waits", 32'(ilat_o), 32'h1000);
      expect_evt(12, 2'd1, 4'b0001, 32'hC000_000C);
      pulse_rti(); idle(3);
      chk("R10 return lets level 12 in", 32'(ipend_o), 32'h1010);
      pulse_gdis(); pulse_rti(); idle(2);

      // held request is taken once only
      expect_evt(5, 2'd1, 4'b0001, 32'hC000_0005);
      req_i[5] = 1'b1; idle(4);
      pulse_gdis(); idle(3);
      chk("R1 held request not relatched", 32'(ilat_o), 32'h0);
      chk("R1 single service", 32'(ipend_o), 32'h0020);
      pulse_rti(); req_i[5] = 1'b0; idle(2);
      chk("R10 idle again", 32'(ipend_o), 32'h0);

      // request on the disable level is ignored
      pulse_req(4); idle(2);
      chk("R1 level 4 never latches", 32'(ilat_o), 32'h0);
      chk("R1 level 4 not pending", 32'(ipend_o), 32'h0);

      idle(4);
      chk("R4 all expected redirects seen", 32'(expq.size()), 32'd0);
      finish_run();
   end
endmodule